// File: doc/BRIEF.md
# Keyed Slow-Clock Source Selector

This block picks the slow timekeeping reference from one of two free-running sources: a fast, imprecise on-chip oscillator (nominally about 667 kHz) or an external 32 kHz crystal clock. Both sources arrive as level signals. The block samples them in the system clock domain and turns each rising edge into a single-cycle event. When the on-chip oscillator is selected, those events pass through a divide-by-(N+1) prescaler. When the crystal is selected, its events pass through unchanged. The result is a one-cycle `tick_o` enable for the downstream timekeeping logic. A gated copy of the tick is also driven on `clk_out_o`.

Software programs the block through a simple 32-bit register port with a write strobe and a combinational read. The block has three registers. The source-select register is guarded by a write key: a write changes the selection only when its upper half holds 0x16AA, and any other write to that register is discarded. The prescaler register holds the ratio N. The output-gate register enables the clock-out copy.

Top module: `lsc_top`

## Requirements
- R1: After reset, the on-chip oscillator is selected, the prescaler is 0, the gate is off, every register reads 0, and `tick_o` and `clk_out_o` are low.
- R2: A write to offset 0x00 whose bits 31:16 equal 0x16AA loads bit 0 into the source select (1 = crystal, 0 = on-chip oscillator). Reads of offset 0x00 return the select in bit 0 and zeros in bits 31:1.
- R3: A write to offset 0x00 whose bits 31:16 differ from 0x16AA is ignored. The readback and the tick rate stay as they were.
- R4: With the on-chip oscillator selected and prescaler value P, `tick_o` pulses once every P+1 rising edges of that oscillator.
- R5: With the crystal selected, `tick_o` pulses once per crystal rising edge, whatever the prescaler value.
- R6: `tick_o` is never high for two consecutive cycles.
- R7: A new prescaler value takes effect only at the next divider terminal count. The interval in progress completes at the old ratio.
- R8: When bit 0 of the gate register (offset 0x60) is set, `clk_out_o` is high in exactly the cycles in which `tick_o` is high. When that bit is clear, `clk_out_o` stays low.
- R9: The prescaler register (offset 0x08) keeps write bits 4:0 and reads them back in bits 4:0, with zeros above. Reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run well above twice the on-chip oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| int_osc | input | 1 | On-chip oscillator level, asynchronous |
| ext_osc | input | 1 | External crystal clock level, asynchronous |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| tick_o | output | 1 | One-cycle enable per slow-clock period |
| clk_out_o | output | 1 | Gated copy of the tick |

## Verification
A source edge reaches `tick_o` three clock edges after it is sampled: two synchronizer stages, then the registered tick. `clk_out_o` is registered in the same cycle as `tick_o`. A register write is visible on `bus_rdata` in the cycle after its strobe. Tick rates are measured as the cycle distance between successive tick pulses, sampled on the falling clock edge. The fixed pipeline delay therefore cancels, and each interval must be an exact multiple of the source period. After any source or ratio change, the first interval is discarded. The exception is the ratio-change test, which checks that interval on purpose.

// File: rtl/lsc_pkg.sv
`timescale 1ns/1ps
package lsc_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned PRESC_W   = 5;
  localparam int unsigned KEY_W     = 16;
  localparam logic [KEY_W-1:0]  WR_KEY     = 16'h16AA;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PRESC  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_GATE   = 8'h60;

  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;
endpackage

// File: rtl/lsc_edge_det.sv
`timescale 1ns/1ps
module lsc_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/lsc_regs.sv
`timescale 1ns/1ps
module lsc_regs
  import lsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output src_e               src_sel_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic               gate_o
);
  src_e               sel_q, sel_d;
  logic [PRESC_W-1:0] presc_q, presc_d;
  logic               gate_q, gate_d;
  logic               key_ok;

  assign key_ok = (bus_wdata[DATA_W-1 -: KEY_W] == WR_KEY);

  always_comb begin
    sel_d   = sel_q;
    presc_d = presc_q;
    gate_d  = gate_q;
    if (bus_we) begin
      unique case (bus_addr)
        OFS_CTRL:  if (key_ok) sel_d = src_e'(bus_wdata[0]);
        OFS_PRESC: presc_d = bus_wdata[PRESC_W-1:0];
        OFS_GATE:  gate_d  = bus_wdata[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= SRC_INT;
      presc_q <= '0;
      gate_q  <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      presc_q <= presc_d;
      gate_q  <= gate_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL:  bus_rdata[0] = sel_q;
      OFS_PRESC: bus_rdata[PRESC_W-1:0] = presc_q;
      OFS_GATE:  bus_rdata[0] = gate_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign src_sel_o = sel_q;
  assign presc_o   = presc_q;
  assign gate_o    = gate_q;
endmodule

// File: rtl/lsc_divider.sv
`timescale 1ns/1ps
module lsc_divider #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [WIDTH-1:0] ratio_i,
  output logic             term_o
);
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic [WIDTH-1:0] ratio_q, ratio_d;
  logic             at_end;

  assign at_end = (cnt_q == ratio_q);
  assign term_o = step_i & at_end;

  always_comb begin
    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    if (step_i) begin
      if (at_end) begin
        cnt_d   = '0;
        ratio_d = ratio_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
    end
  end
endmodule

// File: rtl/lsc_top.sv
`timescale 1ns/1ps
module lsc_top
  import lsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               int_osc,
  input  logic               ext_osc,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               tick_o,
  output logic               clk_out_o
);
  logic [1:0]         rst_pipe_q;
  logic               rst_n_sync;
  logic [1:0]         src_raw;
  logic [1:0]         src_rise;
  src_e               src_sel;
  logic [PRESC_W-1:0] presc;
  logic               gate_en;
  logic               int_term;
  logic               tick_d, tick_q;
  logic               clk_out_d, clk_out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  assign src_raw = {ext_osc, int_osc};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    lsc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .async_in (src_raw[g]),
      .rise_o   (src_rise[g])
    );
  end

  lsc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_sel_o (src_sel),
    .presc_o   (presc),
    .gate_o    (gate_en)
  );

  lsc_divider #(.WIDTH(PRESC_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .step_i  (src_rise[0]),
    .ratio_i (presc),
    .term_o  (int_term)
  );

  always_comb begin
    tick_d    = (src_sel == SRC_EXT) ? src_rise[1] : int_term;
    clk_out_d = tick_d & gate_en;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      tick_q    <= 1'b0;
      clk_out_q <= 1'b0;
    end else begin
      tick_q    <= tick_d;
      clk_out_q <= clk_out_d;
    end
  end

  assign tick_o    = tick_q;
  assign clk_out_o = clk_out_q;
endmodule

// File: rtl/lsc_chk.sv
`timescale 1ns/1ps
module lsc_chk
  import lsc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               sel,
  input logic               gate,
  input logic               tick,
  input logic               clk_out
);
  // R2
  keyed_select_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_CTRL && bus_wdata[31:16] == WR_KEY)
      |=> (sel == $past(bus_wdata[0])));

  // R3
  unkeyed_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_CTRL && bus_wdata[31:16] != WR_KEY) |=> $stable(sel));

  // R2
  ctrl_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL) |-> (bus_rdata[31:1] == '0));

  // R6
  tick_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R8
  clk_out_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out |-> tick);

  // R8
  clk_out_gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gate) |-> !clk_out);
endmodule

bind lsc_top lsc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .sel       (src_sel),
  .gate      (gate_en),
  .tick      (tick_o),
  .clk_out   (clk_out_o)
);

// File: tb/tb_lsc_top.sv
`timescale 1ns/1ps
module tb_lsc_top;
  localparam int NV = 6;
  // columns: control write data, prescaler, gate, expected interval in cycles
  localparam logic [31:0] V_CTRL [NV] = '{32'h16AA_0000, 32'h16AA_0000, 32'h16AA_0000,
                                          32'h16AA_0001, 32'h16AA_0000, 32'h16AA_0001};
  localparam logic [4:0]  V_PRESC[NV] = '{5'd0, 5'd2, 5'd5, 5'd5, 5'd31, 5'd0};
  localparam logic        V_GATE [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam int          V_EXP  [NV] = '{8, 24, 48, 20, 256, 20};

  logic        clk, rst_n, int_osc, ext_osc, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tick_o, clk_out_o;
  int          checks = 0, errors = 0;
  longint      cyc = 0;

  lsc_top dut (.*);

  initial begin clk = 1'b0; forever #2 clk = ~clk; end
  initial begin int_osc = 1'b0; #1; forever #16 int_osc = ~int_osc; end
  initial begin ext_osc = 1'b0; #3; forever #40 ext_osc = ~ext_osc; end
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  // waits for a tick, checks its width and the clock-out copy
  task automatic wait_tick(input logic gate, output longint t);
    @(negedge clk);
    while (tick_o !== 1'b1) @(negedge clk);
    t = cyc;
    chk("R8 clk_out with tick", clk_out_o, gate);
    @(negedge clk);
    chk("R6 tick width", tick_o, 0);
    chk("R8 clk_out after tick", clk_out_o, 0);
  endtask

  longint t0, t1, t2;

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    chk("R1 tick in reset", tick_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R1 ctrl reset", 8'h00, 32'h0);
    rd_chk("R1 presc reset", 8'h08, 32'h0);
    rd_chk("R1 gate reset", 8'h60, 32'h0);
    chk("R1 clk_out reset", clk_out_o, 0);
    // R1: reset ratio 0 gives one tick per internal edge
    wait_tick(1'b0, t0); wait_tick(1'b0, t1);
    chk("R1 R4 reset interval", t1 - t0, 8);

    // vector table: R2 R4 R5 R8
    for (int i = 0; i < NV; i++) begin
      wr(8'h08, {27'h0, V_PRESC[i]});
      wr(8'h60, {31'h0, V_GATE[i]});
      wr(8'h00, V_CTRL[i]);
      rd_chk("R2 ctrl readback", 8'h00, {31'h0, V_CTRL[i][0]});
      wait_tick(V_GATE[i], t0);
      wait_tick(V_GATE[i], t1);
      wait_tick(V_GATE[i], t2);
      chk(V_CTRL[i][0] ? "R5 crystal interval" : "R4 divided interval", t2 - t1, V_EXP[i]);
    end

    // R9: prescaler keeps bits 4:0 only; unmapped reads zero
    wr(8'h08, 32'hFFFF_FFE3);
    rd_chk("R9 presc readback", 8'h08, 32'h0000_0003);
    rd_chk("R9 unmapped read", 8'h44, 32'h0);

    // R3: unkeyed write to select crystal is dropped (currently crystal, so select internal first)
    wr(8'h00, 32'h16AA_0000);
    wr(8'h60, 32'h1);
    wr(8'h00, 32'h1234_0001);
    rd_chk("R3 ctrl unchanged", 8'h00, 32'h0);
    wr(8'h00, 32'h0000_0001);
    rd_chk("R3 ctrl unchanged zero key", 8'h00, 32'h0);
    wait_tick(1'b1, t0); wait_tick(1'b1, t1); wait_tick(1'b1, t2);
    chk("R3 rate unchanged", t2 - t1, 32);

    // R7: change ratio mid-interval; current interval finishes at old ratio
    wait_tick(1'b1, t0);
    wr(8'h08, 32'h1);
    wait_tick(1'b1, t1);
    wait_tick(1'b1, t2);
    chk("R7 old ratio completes", t1 - t0, 32);
    chk("R7 new ratio after terminal", t2 - t1, 16);

    // R8: gate off silences clock-out
    wr(8'h60, 32'h0);
    wait_tick(1'b0, t0);
    wait_tick(1'b0, t1);
    chk("R8 gated interval", t1 - t0, 16);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule